// File: doc/BRIEF.md
# TDM Serial Audio Slot Transmitter

This block turns a set of parallel 24-bit audio samples into one time-division-multiplexed serial data stream. Each frame lasts exactly 256 bit-clock periods. The block runs on the bit clock itself. It changes its data output on the falling edge so that a receiver can sample the data on the rising edge. Its data output has a separate output-enable. The enable is asserted only during the bit times of the slots this transmitter owns, so several transmitters can share one data wire.

The block works in one of two timing roles. As clock master it generates the frame sync itself, as a square wave with equal high and low times. As slave it follows an external frame sync, and only the rising edge of that sync matters: a one-clock pulse and a square wave both work. There are two slot layouts. The packed layout places 24-bit slots back to back. The wide layout uses 32-bit slots, in which the 24 data bits are followed by 8 idle bit times. The first slot the block owns is set by a slot offset, and the number of slots it owns is set by a channel count.

Samples and configuration are captured at the start of each frame. The capture is marked by a one-clock strobe, so the source may update its inputs at any time without disturbing the frame in flight.

Top module: `tdm_slot_tx`

## Requirements
- R1: In master mode `fs_out` is high for 128 consecutive bit periods and low for the next 128. It rises one bit period before frame position 0, and the frame repeats every 256 bit periods. In slave mode `fs_out` stays low.
- R2: With `cfg_wide` = 0 (packed), slot k (0-based) occupies frame positions 24k to 24k+23 for k = 0..9. Positions 240 to 255 are never driven.
- R3: With `cfg_wide` = 1 (wide), slot k occupies positions 32k to 32k+23 for k = 0..7. Positions 32k+24 to 32k+31 are never driven.
- R4: Within a slot, bit b (0-based, in time order) carries bit 23-b of the sample, so the MSB goes first. Each bit is launched on a falling edge of `clk`.
- R5: Slot `cfg_offset`+j carries channel j for j = 0..`cfg_nch`-1. Channel j is `samples_i[24j+23:24j]`. In every other bit time `sd_oe_o` is 0 and `sd_o` is 0.
- R6: In slave mode a frame starts at the rising clock edge at which `fs_in` is sampled high after having been sampled low. The bit launched on the next falling edge is position 0. Both a one-period pulse and a 50% duty square wave are accepted.
- R7: In slave mode nothing is driven after reset until the first qualifying rising edge of `fs_in`.
- R8: `samples_i`, `cfg_wide`, `cfg_offset` and `cfg_nch` are captured at the frame start. Changes to them during a frame do not affect that frame.
- R9: A slot beyond the last slot of the layout is never driven, so channels that do not fit are dropped. `err_o` is 1 for a frame exactly when `cfg_offset`+`cfg_nch` exceeds 10 (packed) or 8 (wide), and it changes only at a frame start.
- R10: `frm_start_o` is 1 during the single bit period at frame position 0 and 0 otherwise.
- R11: While `rst` is high, `sd_o`, `sd_oe_o`, `fs_out`, `frm_start_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 256 periods per frame |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate frame sync; 0: follow `fs_in` (static between resets) |
| cfg_wide | input | 1 | Slot layout: 0 packed 24-bit, 1 wide 32-bit |
| cfg_offset | input | 4 | Index of the first slot owned |
| cfg_nch | input | 4 | Number of channels to send (0..MAX_CH) |
| samples_i | input | MAX_CH*24 (192) | Parallel samples, channel j at bits 24j+23:24j |
| fs_in | input | 1 | External frame sync in slave mode |
| fs_out | output | 1 | Generated frame sync in master mode |
| frm_start_o | output | 1 | Frame-start strobe, samples captured |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Output enable for the shared data line |
| err_o | output | 1 | Channel count does not fit the layout |

## Verification
The assertions check on every cycle that the data line is quiet whenever it is released and that the start strobe never lasts two cycles. They also check that a master sync rise is followed by a frame start, that the sync stays low in slave mode, and that the overflow flag moves only at a frame start. Only the bench scenarios can show the bit-exact slot placement and MSB-first ordering in both layouts, the slot offset and dropped channels, the silence before the first slave sync, and the immunity to mid-frame input changes. The bench compares every bit period against a model built from frame position arithmetic.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int FRAME_BITS     = 256;
  localparam int POS_W          = $clog2(FRAME_BITS);
  localparam int SAMPLE_W       = 24;
  localparam int WIDE_SLOT_BITS = 32;
  localparam int BIT_W          = $clog2(WIDE_SLOT_BITS);
  localparam int PACK_SLOTS     = FRAME_BITS / SAMPLE_W;
  localparam int WIDE_SLOTS     = FRAME_BITS / WIDE_SLOT_BITS;
  localparam int SLOT_W         = 4;

  typedef enum logic {
    LAYOUT_PACKED = 1'b0,
    LAYOUT_WIDE   = 1'b1
  } layout_e;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic fs_in,
  output logic start,
  output logic adv,
  output logic fs_out
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  logic             fs_prev;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_inc;

  always_comb begin
    pos_inc = pos_q + 1'b1;
    start   = master ? (pos_q == LAST) : (fs_in & ~fs_prev);
    adv     = ~start & (pos_q != LAST);
  end

  // position counter; in slave mode it parks at LAST until the next sync rise
  always_ff @(posedge clk) begin
    if (rst) begin
      fs_prev <= 1'b1;
      pos_q   <= master ? (LAST - 1'b1) : LAST;
    end else begin
      fs_prev <= fs_in;
      if (start)    pos_q <= '0;
      else if (adv) pos_q <= pos_inc;
    end
  end

  // generated sync is high from the period before position 0 for half a frame
  always_ff @(negedge clk) begin
    if (rst) fs_out <= 1'b0;
    else     fs_out <= master & ~pos_inc[POS_W-1];
  end
endmodule

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  layout_e           layout,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitn
);
  localparam logic [BIT_W-1:0] PACK_LAST = BIT_W'(SAMPLE_W - 1);
  localparam logic [BIT_W-1:0] WIDE_LAST = BIT_W'(WIDE_SLOT_BITS - 1);

  logic [BIT_W-1:0] last_bit;

  always_comb begin
    last_bit = (layout == LAYOUT_WIDE) ? WIDE_LAST : PACK_LAST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '1;
      bitn <= '0;
    end else if (start) begin
      slot <= '0;
      bitn <= '0;
    end else if (adv) begin
      if (bitn == last_bit) begin
        bitn <= '0;
        if (slot != '1) slot <= slot + 1'b1;
      end else begin
        bitn <= bitn + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer
  import tdm_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CNT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [MAX_CH*SAMPLE_W-1:0] samples,
  input  logic                       cfg_wide,
  input  logic [SLOT_W-1:0]          cfg_off,
  input  logic [CNT_W-1:0]           cfg_nch,
  input  logic [SLOT_W-1:0]          slot,
  input  logic [BIT_W-1:0]           bitn,
  output layout_e                    layout_q,
  output logic                       sd,
  output logic                       oe,
  output logic                       err,
  output logic                       frm
);
  localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;
  localparam int SUM_W = ((SLOT_W > CNT_W) ? SLOT_W : CNT_W) + 1;
  localparam logic [CNT_W-1:0] NCH_MAX = CNT_W'(MAX_CH);

  logic [SAMPLE_W-1:0] lane   [MAX_CH];
  logic [SAMPLE_W-1:0] shadow [MAX_CH];

  logic [SLOT_W-1:0] off_q;
  logic [CNT_W-1:0]  nch_q;
  logic [CNT_W-1:0]  nch_in;
  logic [SUM_W-1:0]  avail_in, avail_q, end_q;
  logic              ovf_in;
  logic              in_data, owned, bit_val;
  logic [CH_W-1:0]   ch_sel;
  logic [BIT_W-1:0]  bit_sel;

  // sample capture at frame start, one word per channel
  for (genvar g = 0; g < MAX_CH; g++) begin : g_lane
    assign lane[g] = samples[g*SAMPLE_W +: SAMPLE_W];
    always_ff @(posedge clk) begin
      if (start) shadow[g] <= lane[g];
    end
  end

  always_comb begin
    nch_in   = (cfg_nch > NCH_MAX) ? NCH_MAX : cfg_nch;
    avail_in = cfg_wide ? SUM_W'(WIDE_SLOTS) : SUM_W'(PACK_SLOTS);
    ovf_in   = (SUM_W'(cfg_off) + SUM_W'(nch_in)) > avail_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      layout_q <= LAYOUT_PACKED;
      off_q    <= '0;
      nch_q    <= '0;
      err      <= 1'b0;
      frm      <= 1'b0;
    end else begin
      frm <= start;
      if (start) begin
        layout_q <= layout_e'(cfg_wide);
        off_q    <= cfg_off;
        nch_q    <= nch_in;
        err      <= ovf_in;
      end
    end
  end

  always_comb begin
    avail_q = (layout_q == LAYOUT_WIDE) ? SUM_W'(WIDE_SLOTS) : SUM_W'(PACK_SLOTS);
    end_q   = SUM_W'(off_q) + SUM_W'(nch_q);
    in_data = bitn < BIT_W'(SAMPLE_W);
    owned   = in_data && (slot >= off_q) && (SUM_W'(slot) < end_q)
              && (SUM_W'(slot) < avail_q);
    ch_sel  = CH_W'(slot - off_q);
    bit_sel = BIT_W'(SAMPLE_W - 1) - bitn;
    bit_val = shadow[ch_sel][bit_sel];
  end

  // launch on the falling edge so the receiver samples mid-bit on the rising edge
  always_ff @(negedge clk) begin
    if (rst) begin
      oe <= 1'b0;
      sd <= 1'b0;
    end else begin
      oe <= owned;
      sd <= owned & bit_val;
    end
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int CNT_W = $clog2(MAX_CH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_master,
  input  logic                       cfg_wide,
  input  logic [SLOT_W-1:0]          cfg_offset,
  input  logic [CNT_W-1:0]           cfg_nch,
  input  logic [MAX_CH*SAMPLE_W-1:0] samples_i,
  input  logic                       fs_in,
  output logic                       fs_out,
  output logic                       frm_start_o,
  output logic                       sd_o,
  output logic                       sd_oe_o,
  output logic                       err_o
);
  logic              start, adv;
  layout_e           layout_q;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitn;

  tdm_frame_timer u_timer (
    .clk    (clk),
    .rst    (rst),
    .master (cfg_master),
    .fs_in  (fs_in),
    .start  (start),
    .adv    (adv),
    .fs_out (fs_out)
  );

  tdm_slot_tracker u_track (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .adv    (adv),
    .layout (layout_q),
    .slot   (slot),
    .bitn   (bitn)
  );

  tdm_slot_serializer #(
    .MAX_CH (MAX_CH),
    .CNT_W  (CNT_W)
  ) u_ser (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .samples  (samples_i),
    .cfg_wide (cfg_wide),
    .cfg_off  (cfg_offset),
    .cfg_nch  (cfg_nch),
    .slot     (slot),
    .bitn     (bitn),
    .layout_q (layout_q),
    .sd       (sd_o),
    .oe       (sd_oe_o),
    .err      (err_o),
    .frm      (frm_start_o)
  );
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk (
  input logic clk,
  input logic rst,
  input logic cfg_master,
  input logic fs_out,
  input logic frm_start_o,
  input logic sd_o,
  input logic sd_oe_o,
  input logic err_o
);
  // R5
  data_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sd_oe_o |-> !sd_o);

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    frm_start_o |=> !frm_start_o);

  // R1
  sync_to_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $rose(fs_out)) |=> frm_start_o);

  // R1
  slave_sync_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |-> !fs_out);

  // R9
  err_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_o) |-> frm_start_o);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk chk_u (
  .clk         (clk),
  .rst         (rst),
  .cfg_master  (cfg_master),
  .fs_out      (fs_out),
  .frm_start_o (frm_start_o),
  .sd_o        (sd_o),
  .sd_oe_o     (sd_oe_o),
  .err_o       (err_o)
);

// File: tb/tdm_slot_tx_test.sv
module tdm_slot_tx_test;
  localparam int MAX_CH = 8;
  localparam int SW     = 24;
  localparam int VEC    = MAX_CH * SW;
  localparam int CNT_W  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_master = 1'b0;
  logic             cfg_wide = 1'b0;
  logic [3:0]       cfg_offset = '0;
  logic [CNT_W-1:0] cfg_nch = '0;
  logic [VEC-1:0]   samples = '0;
  logic             fs_in = 1'b0;
  logic             fs_out, frm_start_o, sd_o, sd_oe_o, err_o;

  int checks = 0;
  int errors = 0;
  int bpos = 255;
  bit started = 0;
  bit fs_before = 1;
  bit done = 0;
  logic [VEC-1:0] fr_samp = '0;
  bit fr_wide = 0;
  int fr_off = 0;
  int fr_nch = 0;

  always #5 clk = ~clk;

  tdm_slot_tx #(.MAX_CH(MAX_CH)) uut (
    .clk         (clk),
    .rst         (rst),
    .cfg_master  (cfg_master),
    .cfg_wide    (cfg_wide),
    .cfg_offset  (cfg_offset),
    .cfg_nch     (cfg_nch),
    .samples_i   (samples),
    .fs_in       (fs_in),
    .fs_out      (fs_out),
    .frm_start_o (frm_start_o),
    .sd_o        (sd_o),
    .sd_oe_o     (sd_oe_o),
    .err_o       (err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s pos=%0d actual=%0d expected=%0d", req, what, bpos, act, exp);
    end
  endtask

  // expected line state from frame position arithmetic
  function automatic void model(input int p, input bit wide, input int off,
                                input int nch, input logic [VEC-1:0] s,
                                output bit oe, output bit d);
    int slot, b;
    oe = 0; d = 0; slot = -1; b = 0;
    if (!wide) begin
      if (p < 240) begin slot = p / 24; b = p % 24; end
    end else begin
      slot = p / 32; b = p % 32;
      if (b >= 24) slot = -1;
    end
    if (slot >= 0 && slot >= off && slot < off + nch) begin
      oe = 1;
      d  = s[(slot - off) * 24 + 23 - b];
    end
  endfunction

  function automatic bit ovf(input int off, input int nch, input bit wide);
    return (off + nch) > (wide ? 8 : 10);
  endfunction

  task automatic new_samples();
    for (int w = 0; w < VEC / 32; w++) samples[w*32 +: 32] = $urandom;
  endtask

  task automatic cycle();
    bit st, eoe, ed, efs, eerr;
    string lbl;
    @(posedge clk); #7;
    if (cfg_master) st = (bpos == 255);
    else            st = fs_in && !fs_before;
    fs_before = fs_in;
    if (st) begin
      bpos = 0; started = 1;
      fr_samp = samples; fr_wide = cfg_wide;
      fr_off = int'(cfg_offset); fr_nch = int'(cfg_nch);
    end else if (cfg_master) bpos = (bpos + 1) % 256;
    else if (bpos < 255) bpos++;
    model(bpos, fr_wide, fr_off, fr_nch, fr_samp, eoe, ed);
    if (!started) begin eoe = 0; ed = 0; end
    efs  = cfg_master && (bpos == 255 || bpos < 127);
    eerr = started && ovf(fr_off, fr_nch, fr_wide);
    if (!started) lbl = "R7";
    else lbl = fr_wide ? "R3 R4 R5 R8 R9" : "R2 R4 R5 R8 R9";
    if (!cfg_master) lbl = {lbl, " R6"};
    check(sd_oe_o === eoe, lbl, "output enable", int'(sd_oe_o), int'(eoe));
    check(sd_o === ed, lbl, "data bit", int'(sd_o), int'(ed));
    check(fs_out === efs, "R1", "frame sync", int'(fs_out), int'(efs));
    check(frm_start_o === st, "R10", "start strobe", int'(frm_start_o), int'(st));
    check(err_o === eerr, "R9", "overflow flag", int'(err_o), int'(eerr));
  endtask

  task automatic do_reset(input bit m);
    rst = 1'b1; cfg_master = m; fs_in = 1'b0;
    repeat (3) begin
      @(posedge clk); #7;
      check(sd_o === 1'b0, "R11", "reset data", int'(sd_o), 0);
      check(sd_oe_o === 1'b0, "R11", "reset enable", int'(sd_oe_o), 0);
      check(fs_out === 1'b0, "R11", "reset sync", int'(fs_out), 0);
      check(frm_start_o === 1'b0, "R11", "reset strobe", int'(frm_start_o), 0);
      check(err_o === 1'b0, "R11", "reset flag", int'(err_o), 0);
    end
    rst = 1'b0;
    bpos = m ? 254 : 255; started = 0; fs_before = 1;
  endtask

  // fsmode 0: one-period pulse; 1: 50% square wave; lead: quiet periods first
  task automatic run(input int ncyc, input int fsmode, input int lead, input bit rnd);
    for (int i = 0; i < ncyc; i++) begin
      cycle();
      if (!cfg_master) begin
        int ph = i + 1 - lead;
        if (ph < 0)           fs_in = 1'b0;
        else if (fsmode == 0) fs_in = ((ph % 256) == 0);
        else                  fs_in = ((ph % 256) < 128);
      end
      if (rnd) begin
        // R8: inputs move in the middle of frames
        if ($urandom_range(19) == 0) new_samples();
        if ($urandom_range(39) == 0) begin
          cfg_offset = 4'($urandom_range(4));
          cfg_nch    = CNT_W'($urandom_range(8));
          cfg_wide   = 1'($urandom_range(1));
        end
      end
    end
  endtask

  task automatic set_cfg(input bit w, input int off, input int n);
    cfg_wide = w; cfg_offset = 4'(off); cfg_nch = CNT_W'(n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    new_samples();
    // master, packed full, then wide, then overflow cases
    set_cfg(0, 0, 8);
    do_reset(1);
    run(600, 0, 1, 0);
    set_cfg(1, 0, 8);  run(520, 0, 1, 0);
    set_cfg(0, 6, 8);  run(520, 0, 1, 0);   // R9 packed: channels 4..7 dropped
    set_cfg(1, 4, 8);  run(520, 0, 1, 0);   // R9 wide: channels 4..7 dropped
    set_cfg(0, 2, 8);  run(520, 0, 1, 0);   // exact fit, no flag
    run(1500, 0, 1, 1);
    // slave with pulse sync, quiet lead first (R7)
    set_cfg(0, 1, 4);
    do_reset(0);
    run(700, 0, 40, 0);
    run(1500, 0, 13, 1);
    // slave with square-wave sync
    set_cfg(1, 2, 5);
    do_reset(0);
    run(700, 1, 25, 0);
    run(2000, 1, 25, 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule